// File: doc/BRIEF.md
# Multi-Mode DMA Channel Controller

This block is a multi-channel, fly-by DMA controller. Software sets up each channel through a small register port. Each channel holds four things: a 16-bit memory address, a 16-bit unit count, a control word and a status word. The control word carries an 8-bit page, the transfer direction, the bus-usage mode and an enable bit.

A peripheral asks for service on its request line. The controller then gets the system bus in one of three ways:
- **Block mode.** It asserts a bus request and keeps the bus until the whole block has moved.
- **Cycle-stealing mode.** It gives the bus back after every unit and asks again for the next one.
- **Hidden mode.** It never asks for the bus. It moves a unit only in a cycle where the CPU reports that it is not using the bus.

Each unit is one clock cycle. In that cycle the controller drives a 24-bit memory address (page followed by the low 16 bits), exactly one of the read or write strobes, and the acknowledge line of the channel being served. The data passes directly between the peripheral and memory.

A block ends in one of two ways:
- **Terminal count.** The count, loaded with N-1, runs out.
- **Boundary error.** A further unit would carry the low address past 0xFFFF. The page is never incremented, so the channel stops instead.

Either ending clears the channel's enable, sets a status bit and raises the interrupt. The engine has four states:
- **IDLE.** Picks the lowest-numbered pending channel. It goes to REQ for block or stealing mode, or to HIDE for hidden mode.
- **REQ.** Holds the bus request and goes to XFER when the grant arrives.
- **XFER.** Moves one unit in every granted cycle. It returns to IDLE after the final unit, or after every unit in stealing mode.
- **HIDE.** Moves a unit whenever the CPU is idle and the request is high. It returns to IDLE after the final unit or when the request drops.

Top module: `dmac_top`

## Requirements
- R1: `reg_sel` is {channel index, register index}. Register index 0 is the address, 1 the count, 2 the control word and 3 the status word. The control word reads and writes as {page[15:8], 4'b0, mode[3:2], dir[1], enable[0]}. Written address, count and control values read back unchanged while the channel is idle.
- R2: Each unit increments the channel's address register by one and decrements its count register by one. A count loaded with N-1 moves exactly N units. A control dir bit of 0 pulses `mem_rd`; a dir bit of 1 pulses `mem_wr`.
- R3: When the unit with count 0 completes, status bit 0 (terminal count) is set and the enable bit clears. Any write to the status register clears both status bits. `irq` is high while any channel has a status bit set.
- R4: Mode 00 (also 11) is block mode. `br` rises once and stays high through every unit of the block. Units occur only while `bg` is high. `br` is low the cycle after the final unit.
- R5: Mode 01 is cycle stealing. `br` goes low for at least one cycle after every unit, so `br` rises once per unit.
- R6: Mode 10 is hidden mode. `br` is never asserted, and a unit occurs only in a cycle where both `cpu_idle` and the channel's request are high.
- R7: `mem_addr` is {page, address register}. The page never changes during or after a block, even when the low address reaches 0xFFFF.
- R8: A unit at low address 0xFFFF with count not 0 is still performed, and the channel then stops. Status bit 1 (boundary error) is set, bit 0 stays clear, the enable clears and `irq` rises.
- R9: `dack` is one-hot during a unit, marks the channel being served, and is zero outside units.
- R10: A channel is pending when it is enabled and its request is high. Among pending channels, the lowest index is served first. The choice is made only in IDLE, at a unit boundary.
- R11: If a status write and the completion of a channel's block fall in the same cycle, the newly set status bit survives the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | {channel index, register index} |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_sel` (combinational) |
| drq | input | 4 | Per-channel service request |
| dack | output | 4 | Per-channel acknowledge during a unit |
| br | output | 1 | System bus request |
| bg | input | 1 | System bus grant |
| cpu_idle | input | 1 | CPU is not using the bus this cycle |
| mem_addr | output | 24 | Memory address {page, low address} |
| mem_rd | output | 1 | Memory read strobe (memory to peripheral) |
| mem_wr | output | 1 | Memory write strobe (peripheral to memory) |
| irq | output | 1 | Block-end interrupt |

## Verification
Two things can land on the same clock edge: a channel's final unit, which sets terminal count, and a software write that clears the same status register. The bench sets this up on a hidden-mode channel that is waiting with its count at 0. In a single cycle it raises `cpu_idle` and issues the status write. It then reads the status back, expecting terminal count still set and `irq` still high. A second, lone write must then clear both.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic [1:0] {
        MODE_BLOCK  = 2'b00,
        MODE_STEAL  = 2'b01,
        MODE_HIDDEN = 2'b10,
        MODE_BLOCK2 = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_REQ,
        S_XFER,
        S_HIDE
    } eng_state_e;

    localparam logic [1:0] RIDX_ADDR  = 2'd0;
    localparam logic [1:0] RIDX_COUNT = 2'd1;
    localparam logic [1:0] RIDX_CTRL  = 2'd2;
    localparam logic [1:0] RIDX_STAT  = 2'd3;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_reg,
    input  logic [AW-1:0] wr_data,
    input  logic [1:0]    rd_reg,
    output logic [AW-1:0] rd_data,
    input  logic          unit_i,
    output logic [AW-1:0] addr_o,
    output logic [PW-1:0] page_o,
    output logic          dir_o,
    output xfer_mode_e    mode_o,
    output logic          en_o,
    output logic          end_o,
    output logic          tc_o,
    output logic          berr_o
);
    localparam int PAGE_LSB = AW - PW;

    logic [AW-1:0] addr_q, count_q;
    logic [PW-1:0] page_q;
    logic          dir_q, en_q, tc_q, berr_q;
    xfer_mode_e    mode_q;
    logic          last_unit, top_unit;

    assign last_unit = (count_q == '0);
    assign top_unit  = (addr_q == '1);
    assign end_o     = last_unit | top_unit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            count_q <= '0;
            page_q  <= '0;
            dir_q   <= 1'b0;
            en_q    <= 1'b0;
            tc_q    <= 1'b0;
            berr_q  <= 1'b0;
            mode_q  <= MODE_BLOCK;
        end else begin
            // status clear first, so a same-cycle completion wins
            if (wr_en && wr_reg == RIDX_STAT) begin
                tc_q   <= 1'b0;
                berr_q <= 1'b0;
            end
            if (unit_i) begin
                addr_q  <= addr_q + 1'b1;
                count_q <= count_q - 1'b1;
                if (last_unit) begin
                    tc_q <= 1'b1;
                    en_q <= 1'b0;
                end else if (top_unit) begin
                    berr_q <= 1'b1;
                    en_q   <= 1'b0;
                end
            end
            if (wr_en) begin
                unique case (wr_reg)
                    RIDX_ADDR:  addr_q  <= wr_data;
                    RIDX_COUNT: count_q <= wr_data;
                    RIDX_CTRL: begin
                        en_q   <= wr_data[0];
                        dir_q  <= wr_data[1];
                        mode_q <= xfer_mode_e'(wr_data[3:2]);
                        page_q <= wr_data[PAGE_LSB +: PW];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_reg)
            RIDX_ADDR:  rd_data = addr_q;
            RIDX_COUNT: rd_data = count_q;
            RIDX_CTRL: begin
                rd_data[PAGE_LSB +: PW] = page_q;
                rd_data[3:0] = {mode_q, dir_q, en_q};
            end
            default:    rd_data[1:0] = {berr_q, tc_q};
        endcase
    end

    assign addr_o = addr_q;
    assign page_o = page_q;
    assign dir_o  = dir_q;
    assign mode_o = mode_q;
    assign en_o   = en_q;
    assign tc_o   = tc_q;
    assign berr_o = berr_q;

    // R3
    tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_i && count_q == '0) |=> tc_q);

    // R8
    berr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_i && count_q != '0 && addr_q == '1 && !wr_en) |=> (berr_q && !en_q));
endmodule

// File: rtl/dmac_arb.sv
module dmac_arb #(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [CW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = CW'(i);
            end
        end
    end
endmodule

// File: rtl/dmac_eng.sv
module dmac_eng
    import dmac_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_pend,
    input  logic [CW-1:0] pick_idx,
    input  xfer_mode_e    pick_mode,
    input  xfer_mode_e    cur_mode,
    input  logic          cur_dir,
    input  logic          cur_drq,
    input  logic          cur_end,
    input  logic          bg,
    input  logic          cpu_idle,
    output logic [CW-1:0] cur_idx,
    output logic          br,
    output logic          unit,
    output logic [N-1:0]  dack,
    output logic          mem_rd,
    output logic          mem_wr
);
    eng_state_e    state_q, state_d;
    logic [CW-1:0] cur_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && any_pend) cur_q <= pick_idx;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (any_pend) state_d = (pick_mode == MODE_HIDDEN) ? S_HIDE : S_REQ;
            S_REQ:  if (bg) state_d = S_XFER;
            S_XFER: if (bg && (cur_end || cur_mode == MODE_STEAL)) state_d = S_IDLE;
            S_HIDE: if ((cpu_idle && cur_drq && cur_end) || !cur_drq) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        br   = 1'b0;
        unit = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_REQ:  br = 1'b1;
            S_XFER: begin
                br   = 1'b1;
                unit = bg;
            end
            S_HIDE: unit = cpu_idle & cur_drq;
            default: ;
        endcase
        dack = '0;
        if (unit) dack[cur_q] = 1'b1;
        mem_rd = unit & ~cur_dir;
        mem_wr = unit & cur_dir;
    end

    assign cur_idx = cur_q;

    // R9
    dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack) && ((mem_rd || mem_wr) == (dack != '0)));

    // R6
    hide_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !br) |-> cpu_idle);

    // R4
    grant_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && br) |-> bg);

    // R5
    steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_XFER && bg && cur_mode == MODE_STEAL) |=> !br);
endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [((N > 1) ? $clog2(N) : 1)+1:0] reg_sel,
    input  logic [AW-1:0]    reg_wdata,
    output logic [AW-1:0]    reg_rdata,
    input  logic [N-1:0]     drq,
    output logic [N-1:0]     dack,
    output logic             br,
    input  logic             bg,
    input  logic             cpu_idle,
    output logic [PW+AW-1:0] mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             irq
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    logic [AW-1:0] addr_a [N];
    logic [AW-1:0] rd_a   [N];
    logic [PW-1:0] page_a [N];
    xfer_mode_e    mode_a [N];
    logic [N-1:0]  dir_v, en_v, end_v, tc_v, berr_v, pend_v;
    logic [CW-1:0] cur_idx, pick_idx, sel_ch;
    logic          any_pend, unit;

    assign sel_ch = reg_sel[CW+1:2];

    for (genvar i = 0; i < N; i++) begin : g_ch
        dmac_chan #(.AW(AW), .PW(PW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_wr && sel_ch == CW'(i)),
            .wr_reg  (reg_sel[1:0]),
            .wr_data (reg_wdata),
            .rd_reg  (reg_sel[1:0]),
            .rd_data (rd_a[i]),
            .unit_i  (unit && cur_idx == CW'(i)),
            .addr_o  (addr_a[i]),
            .page_o  (page_a[i]),
            .dir_o   (dir_v[i]),
            .mode_o  (mode_a[i]),
            .en_o    (en_v[i]),
            .end_o   (end_v[i]),
            .tc_o    (tc_v[i]),
            .berr_o  (berr_v[i])
        );
    end

    assign pend_v = en_v & drq;

    dmac_arb #(.N(N), .CW(CW)) u_arb (
        .req (pend_v),
        .any (any_pend),
        .idx (pick_idx)
    );

    dmac_eng #(.N(N), .CW(CW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_pend  (any_pend),
        .pick_idx  (pick_idx),
        .pick_mode (mode_a[pick_idx]),
        .cur_mode  (mode_a[cur_idx]),
        .cur_dir   (dir_v[cur_idx]),
        .cur_drq   (drq[cur_idx]),
        .cur_end   (end_v[cur_idx]),
        .bg        (bg),
        .cpu_idle  (cpu_idle),
        .cur_idx   (cur_idx),
        .br        (br),
        .unit      (unit),
        .dack      (dack),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    always_comb begin
        reg_rdata = '0;
        if (int'(sel_ch) < N) reg_rdata = rd_a[sel_ch];
    end

    assign mem_addr = {page_a[cur_idx], addr_a[cur_idx]};
    assign irq      = |(tc_v | berr_v);

    // R7
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && $past(mem_rd || mem_wr) && dack == $past(dack))
        |-> mem_addr[PW+AW-1:AW] == $past(mem_addr[PW+AW-1:AW]));
endmodule

// File: tb/sim_dmac_top.sv
`timescale 1ns/1ps
module sim_dmac_top;
    localparam int N = 4;
    localparam time CYC = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [N-1:0] drq = '0;
    logic [N-1:0] dack;
    logic        br;
    logic        bg = 1'b0;
    logic        cpu_idle = 1'b0;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr, irq;

    int checks = 0;
    int fails  = 0;

    logic [23:0] log_addr [32];
    logic [N-1:0] log_dack [32];
    logic        log_wr   [32];
    logic        log_idle [32];
    logic        log_br   [32];
    int          nlog = 0;
    int          br_rises = 0;
    logic        br_prev = 1'b0;

    always #(CYC/2) clk = ~clk;

    dmac_top #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drq(drq), .dack(dack),
        .br(br), .bg(bg), .cpu_idle(cpu_idle), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .irq(irq)
    );

    // bus owner model and transfer monitor, away from the rising edge
    always @(negedge clk) begin
        if (mem_rd || mem_wr) begin
            if (nlog < 32) begin
                log_addr[nlog] = mem_addr;
                log_dack[nlog] = dack;
                log_wr[nlog]   = mem_wr;
                log_idle[nlog] = cpu_idle;
                log_br[nlog]   = br;
            end
            nlog++;
        end
        if (br && !br_prev) br_rises++;
        br_prev = br;
        bg = br;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input int ch, input int r, input logic [15:0] v);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_sel = {2'(ch), 2'(r)}; reg_wdata = v;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input int ch, input int r, output logic [15:0] v);
        @(posedge clk); #2;
        reg_sel = {2'(ch), 2'(r)};
        @(negedge clk);
        v = reg_rdata;
    endtask

    task automatic clear_log();
        @(negedge clk);
        nlog = 0;
        br_rises = 0;
    endtask

    task automatic wait_irq(input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rreg(0, 3, v);
        chk(v == 16'h0, "R3 reset status", v, 0);
        rreg(0, 2, v);
        chk(v == 16'h0, "R1 reset ctrl", v, 0);
        chk(!irq && !br && dack == '0 && !mem_rd && !mem_wr, "R9 reset outputs",
            {irq, br, dack, mem_rd, mem_wr}, 0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wreg(3, 0, 16'hBEEF);
        wreg(3, 1, 16'h1234);
        wreg(3, 2, 16'hAB0C);
        rreg(3, 0, v); chk(v == 16'hBEEF, "R1 addr readback", v, 16'hBEEF);
        rreg(3, 1, v); chk(v == 16'h1234, "R1 count readback", v, 16'h1234);
        rreg(3, 2, v); chk(v == 16'hAB0C, "R1 ctrl readback", v, 16'hAB0C);
    endtask

    task automatic t_block();
        logic [15:0] v;
        bit ok;
        wreg(0, 0, 16'h0010);
        wreg(0, 1, 16'h0003);
        wreg(0, 2, 16'h1201);
        clear_log();
        @(posedge clk); #2; drq[0] = 1'b1;
        wait_irq(100);
        @(posedge clk); #2; drq[0] = 1'b0;
        @(negedge clk);
        chk(nlog == 4, "R2 block unit count", nlog, 4);
        ok = 1'b1;
        for (int i = 0; i < 4; i++)
            if (log_addr[i] != 24'h120010 + i || log_dack[i] != 4'b0001 || log_wr[i] || !log_br[i]) ok = 1'b0;
        chk(ok, "R7 R9 block addresses/dack/read", log_addr[3], 24'h120013);
        chk(br_rises == 1, "R4 block single request", br_rises, 1);
        chk(!br, "R4 bus released after block", br, 0);
        rreg(0, 3, v); chk(v == 16'h0001, "R3 terminal count status", v, 1);
        chk(irq, "R3 irq on completion", irq, 1);
        rreg(0, 2, v); chk(v == 16'h1200, "R3 enable cleared", v, 16'h1200);
        rreg(0, 0, v); chk(v == 16'h0014, "R2 address advanced", v, 16'h0014);
        rreg(0, 1, v); chk(v == 16'hFFFF, "R2 count underflowed", v, 16'hFFFF);
        wreg(0, 3, 16'h0);
        rreg(0, 3, v); chk(v == 16'h0 && !irq, "R3 status clear", {irq, v}, 0);
    endtask

    task automatic t_steal();
        logic [15:0] v;
        bit ok;
        wreg(1, 0, 16'h0100);
        wreg(1, 1, 16'h0002);
        wreg(1, 2, 16'h0507);
        clear_log();
        @(posedge clk); #2; drq[1] = 1'b1;
        wait_irq(100);
        @(posedge clk); #2; drq[1] = 1'b0;
        @(negedge clk);
        chk(nlog == 3, "R2 steal unit count", nlog, 3);
        chk(br_rises == 3, "R5 request per unit", br_rises, 3);
        ok = 1'b1;
        for (int i = 0; i < 3; i++)
            if (log_addr[i] != 24'h050100 + i || log_dack[i] != 4'b0010 || !log_wr[i]) ok = 1'b0;
        chk(ok, "R2 R9 steal write strobes", log_addr[2], 24'h050102);
        wreg(1, 3, 16'h0);
        rreg(1, 3, v); chk(v == 16'h0, "R3 steal status cleared", v, 0);
    endtask

    task automatic t_hidden();
        bit ok;
        wreg(2, 0, 16'h0200);
        wreg(2, 1, 16'h0004);
        wreg(2, 2, 16'h0709);
        clear_log();
        @(posedge clk); #2; drq[2] = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #2;
            cpu_idle = (i % 3 == 0);
            if (irq) break;
        end
        cpu_idle = 1'b0; drq[2] = 1'b0;
        @(negedge clk);
        chk(nlog == 5, "R6 hidden unit count", nlog, 5);
        chk(br_rises == 0, "R6 no bus request", br_rises, 0);
        ok = 1'b1;
        for (int i = 0; i < 5; i++)
            if (!log_idle[i] || log_addr[i] != 24'h070200 + i || log_dack[i] != 4'b0100) ok = 1'b0;
        chk(ok, "R6 units only in idle cycles", log_addr[4], 24'h070204);
        wreg(2, 3, 16'h0);
    endtask

    task automatic t_boundary();
        logic [15:0] v;
        wreg(0, 0, 16'hFFFE);
        wreg(0, 1, 16'h0004);
        wreg(0, 2, 16'h3401);
        clear_log();
        @(posedge clk); #2; drq[0] = 1'b1;
        wait_irq(100);
        @(posedge clk); #2; drq[0] = 1'b0;
        repeat (3) @(negedge clk);
        chk(nlog == 2, "R8 stop at boundary", nlog, 2);
        chk(log_addr[0] == 24'h34FFFE && log_addr[1] == 24'h34FFFF, "R7 page held at wrap",
            log_addr[1], 24'h34FFFF);
        rreg(0, 3, v); chk(v == 16'h0002, "R8 boundary status", v, 2);
        chk(irq, "R8 irq on boundary", irq, 1);
        rreg(0, 2, v); chk(v == 16'h3400, "R8 R7 enable off page kept", v, 16'h3400);
        wreg(0, 3, 16'h0);
    endtask

    task automatic t_priority();
        logic [15:0] v;
        wreg(3, 0, 16'h0300); wreg(3, 1, 16'h0001); wreg(3, 2, 16'h0005);
        wreg(1, 0, 16'h0110); wreg(1, 1, 16'h0001); wreg(1, 2, 16'h0005);
        clear_log();
        @(posedge clk); #2; drq[1] = 1'b1; drq[3] = 1'b1;
        repeat (40) @(negedge clk);
        @(posedge clk); #2; drq = '0;
        @(negedge clk);
        chk(nlog == 4, "R10 both served", nlog, 4);
        chk(log_dack[0] == 4'b0010 && log_dack[1] == 4'b0010 &&
            log_dack[2] == 4'b1000 && log_dack[3] == 4'b1000, "R10 lowest index first",
            {log_dack[0], log_dack[1], log_dack[2], log_dack[3]}, 16'h2288);
        chk(log_addr[0] == 24'h000110 && log_addr[2] == 24'h000300, "R10 channel addresses",
            log_addr[2], 24'h000300);
        wreg(1, 3, 16'h0); wreg(3, 3, 16'h0);
        rreg(3, 3, v); chk(v == 16'h0 && !irq, "R3 irq low after clears", {irq, v}, 0);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        wreg(2, 0, 16'h0400); wreg(2, 1, 16'h0000); wreg(2, 2, 16'h0009);
        @(posedge clk); #2; drq[2] = 1'b1; cpu_idle = 1'b1;
        wait_irq(20);
        @(posedge clk); #2; cpu_idle = 1'b0;
        wreg(2, 0, 16'h0410); wreg(2, 1, 16'h0000); wreg(2, 2, 16'h0009);
        clear_log();
        repeat (3) @(posedge clk);
        #2; reg_wr = 1'b1; reg_sel = 4'b1011; reg_wdata = 16'h0; cpu_idle = 1'b1;
        @(posedge clk); #2; reg_wr = 1'b0; cpu_idle = 1'b0; drq[2] = 1'b0;
        @(negedge clk);
        chk(nlog == 1, "R11 unit in collision cycle", nlog, 1);
        rreg(2, 3, v); chk(v == 16'h0001, "R11 set beats clear", v, 1);
        chk(irq, "R11 irq held", irq, 1);
        wreg(2, 3, 16'h0);
        rreg(2, 3, v); chk(v == 16'h0 && !irq, "R3 lone clear", {irq, v}, 0);
    endtask

    initial begin
        #(CYC * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2; rst_n = 1'b1;
        t_reset();
        t_regs();
        t_block();
        t_steal();
        t_hidden();
        t_boundary();
        t_priority();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule